// File: doc/BRIEF.md
# UART FIFO Line Status and Polled-Mode Selector

This block assembles the eight-bit line status word of a UART running with its FIFOs, and decides, separately for the receive side and the transmit side, whether the UART is in FIFO polled mode. FIFO storage and serial bit timing live elsewhere. The block is fed the FIFO occupancy counts, the error tag of the character at the receive FIFO head, push and pop strobes with their tags, an overrun pulse, the transmit shift-register-empty flag, the FIFO-enable bit and the four interrupt-enable bits.

Software reads the status word to service a direction that runs without interrupts. Ready, head-character errors and transmitter state come straight from the inputs. The overrun flag is held until a status read. A running count of error-tagged characters still inside the receive FIFO drives the summary error bit. The block also gates the trigger-level, timeout and transmit-empty notifications, so a direction in polled mode raises none of them while its FIFO keeps storing characters.

Top module: `uart_lsr_polled`

## Requirements
- R1: `rx_polled` is 1 exactly when `fifo_en` is 1 and `ier[0]` and `ier[2]` are both 0. `tx_polled` is 1 exactly when `fifo_en` is 1 and `ier[1]` is 0. `ier[3]` affects neither flag.
- R2: `lsr[0]` is 1 whenever `rx_count` is non-zero, and 0 otherwise.
- R3: `lsr[2]`, `lsr[3]` and `lsr[4]` copy the head tag bits 0 (parity), 1 (framing) and 2 (break) while `rx_count` is non-zero, and are 0 when the receive FIFO is empty.
- R4: `lsr[1]` becomes 1 in the cycle after an `rx_overrun` pulse and stays 1 until the cycle after an `lsr_rd` strobe. A pulse in the same cycle as the read wins.
- R5: `lsr[5]` is 1 exactly when `tx_count` is 0.
- R6: `lsr[6]` is 1 exactly when `tx_count` is 0 and `tsr_empty` is 1.
- R7: with `fifo_en` at 1, `lsr[7]` is 1 exactly when at least one character with a non-zero tag is held in the receive FIFO. A character counts from the cycle after its push until the cycle after its pop. With `fifo_en` at 0, `lsr[7]` is 0.
- R8: `rx_flush` empties the error-character tally, so `lsr[7]` is 0 in the next cycle. A push in the same cycle is discarded.
- R9: `rx_notify` is 1 exactly when `fifo_en` and `ier[0]` are 1 and either `rx_trig_hit` or `rx_timeout_hit` is 1. `tx_notify` is 1 exactly when `fifo_en` and `ier[1]` are 1 and `tx_count` is 0. Neither is raised in the polled mode of its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO enable control bit |
| ier | input | 4 | Interrupt-enable bits |
| rx_count | input | CNT_W | Characters held in the receive FIFO |
| rx_push | input | 1 | Character written into the receive FIFO |
| rx_push_tag | input | 3 | Error tag of the pushed character (bit0 parity, bit1 framing, bit2 break) |
| rx_pop | input | 1 | Head character removed from the receive FIFO |
| rx_head_tag | input | 3 | Error tag of the head character, same encoding |
| rx_flush | input | 1 | Receive FIFO reset |
| rx_overrun | input | 1 | Overrun event pulse |
| rx_trig_hit | input | 1 | Receive trigger level reached |
| rx_timeout_hit | input | 1 | Receive character timeout reached |
| tx_count | input | CNT_W | Characters held in the transmit FIFO |
| tsr_empty | input | 1 | Transmit shift register empty |
| lsr_rd | input | 1 | Status word read strobe |
| lsr | output | 8 | Line status word |
| rx_polled | output | 1 | Receiver in FIFO polled mode |
| tx_polled | output | 1 | Transmitter in FIFO polled mode |
| rx_notify | output | 1 | Receive data notification |
| tx_notify | output | 1 | Transmit empty notification |

## Verification
The bench builds the block with a FIFO depth of 4. At that depth the random traffic fills the receive FIFO to its limit and drains it to empty again many times. This exercises the error tally at both ends, including a tagged character pushed while another is popped. It also lets the transmit count sit at zero often enough to cover every combination of the two transmit status bits with the shift register flag.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } err_tag_t;

    typedef struct packed {
        logic rx_err_any;
        logic tx_idle;
        logic tx_empty;
        logic brk;
        logic frm;
        logic par;
        logic ovr;
        logic dready;
    } lsr_word_t;

    typedef struct packed {
        logic rx_data;
        logic tx_empty;
        logic rx_line;
        logic modem;
    } ier_bits_t;

    function automatic ier_bits_t unpack_ier(input logic [3:0] raw);
        ier_bits_t r;
        r.rx_data  = raw[0];
        r.tx_empty = raw[1];
        r.rx_line  = raw[2];
        r.modem    = raw[3];
        return r;
    endfunction

    function automatic logic tag_any(input err_tag_t t);
        return t.par | t.frm | t.brk;
    endfunction

    function automatic err_tag_t mask_tag(input err_tag_t t, input logic keep);
        err_tag_t r;
        r.par = t.par & keep;
        r.frm = t.frm & keep;
        r.brk = t.brk & keep;
        return r;
    endfunction

endpackage

// File: rtl/lsr_mode_sel.sv
module lsr_mode_sel
    import uart_lsr_pkg::*;
(
    input  logic       fifo_en,
    input  logic [3:0] ier,
    input  logic       trig_hit,
    input  logic       timeout_hit,
    input  logic       tx_empty,
    output logic       rx_polled,
    output logic       tx_polled,
    output logic       rx_notify,
    output logic       tx_notify
);
    ier_bits_t en;
    logic      rx_irq_mode;
    logic      tx_irq_mode;

    always_comb begin
        en          = unpack_ier(ier);
        rx_irq_mode = fifo_en & (en.rx_data | en.rx_line);
        tx_irq_mode = fifo_en & en.tx_empty;
        rx_polled   = fifo_en & ~rx_irq_mode;
        tx_polled   = fifo_en & ~tx_irq_mode;
        rx_notify   = fifo_en & en.rx_data & (trig_hit | timeout_hit) & ~rx_polled;
        tx_notify   = tx_irq_mode & tx_empty & ~tx_polled;
    end
endmodule

// File: rtl/lsr_rx_track.sv
module lsr_rx_track
    import uart_lsr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int ERR_W = $clog2(DEPTH + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  err_tag_t push_tag,
    input  logic     pop,
    input  err_tag_t head_tag,
    input  logic     flush,
    input  logic     overrun,
    input  logic     status_rd,
    output logic     err_pending,
    output logic     ovr_flag
);
    localparam logic [ERR_W-1:0] ONE  = ERR_W'(1);
    localparam logic [ERR_W-1:0] FULL = ERR_W'(DEPTH);

    logic [ERR_W-1:0] err_cnt;
    logic             inc;
    logic             dec;

    always_comb begin
        inc = push & tag_any(push_tag);
        dec = pop & tag_any(head_tag) & (err_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            err_cnt <= '0;
        end else if (inc && !dec) begin
            if (err_cnt != FULL) err_cnt <= err_cnt + ONE;
        end else if (dec && !inc) begin
            err_cnt <= err_cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            ovr_flag <= 1'b0;
        else if (overrun)   ovr_flag <= 1'b1;
        else if (status_rd) ovr_flag <= 1'b0;
    end

    assign err_pending = (err_cnt != '0);
endmodule

// File: rtl/lsr_tx_status.sv
module lsr_tx_status #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tsr_empty,
    output logic             tx_empty,
    output logic             tx_idle
);
    always_comb begin
        tx_empty = (tx_count == '0);
        tx_idle  = tx_empty & tsr_empty;
    end
endmodule

// File: rtl/uart_lsr_polled.sv
module uart_lsr_polled
    import uart_lsr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [3:0]       ier,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic [2:0]       rx_push_tag,
    input  logic             rx_pop,
    input  logic [2:0]       rx_head_tag,
    input  logic             rx_flush,
    input  logic             rx_overrun,
    input  logic             rx_trig_hit,
    input  logic             rx_timeout_hit,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tsr_empty,
    input  logic             lsr_rd,
    output logic [7:0]       lsr,
    output logic             rx_polled,
    output logic             tx_polled,
    output logic             rx_notify,
    output logic             tx_notify
);
    logic      err_pending;
    logic      ovr_flag;
    logic      tx_empty;
    logic      tx_idle;
    logic      rx_has_data;
    err_tag_t  head_vis;
    lsr_word_t word;

    lsr_rx_track #(.DEPTH(DEPTH)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .push        (rx_push),
        .push_tag    (err_tag_t'(rx_push_tag)),
        .pop         (rx_pop),
        .head_tag    (err_tag_t'(rx_head_tag)),
        .flush       (rx_flush),
        .overrun     (rx_overrun),
        .status_rd   (lsr_rd),
        .err_pending (err_pending),
        .ovr_flag    (ovr_flag)
    );

    lsr_tx_status #(.DEPTH(DEPTH)) u_tx (
        .tx_count  (tx_count),
        .tsr_empty (tsr_empty),
        .tx_empty  (tx_empty),
        .tx_idle   (tx_idle)
    );

    lsr_mode_sel u_mode (
        .fifo_en     (fifo_en),
        .ier         (ier),
        .trig_hit    (rx_trig_hit),
        .timeout_hit (rx_timeout_hit),
        .tx_empty    (tx_empty),
        .rx_polled   (rx_polled),
        .tx_polled   (tx_polled),
        .rx_notify   (rx_notify),
        .tx_notify   (tx_notify)
    );

    always_comb begin
        rx_has_data     = (rx_count != '0);
        head_vis        = mask_tag(err_tag_t'(rx_head_tag), rx_has_data);
        word.dready     = rx_has_data;
        word.ovr        = ovr_flag;
        word.par        = head_vis.par;
        word.frm        = head_vis.frm;
        word.brk        = head_vis.brk;
        word.tx_empty   = tx_empty;
        word.tx_idle    = tx_idle;
        word.rx_err_any = fifo_en & err_pending;
        lsr             = word;
    end
endmodule

// File: rtl/lsr_polled_checker.sv
module lsr_polled_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_push,
    input logic [2:0]       rx_push_tag,
    input logic             rx_pop,
    input logic             rx_flush,
    input logic             rx_overrun,
    input logic             lsr_rd,
    input logic [7:0]       lsr,
    input logic             rx_polled,
    input logic             tx_polled,
    input logic             rx_notify,
    input logic             tx_notify
);
    assert_no_polled_without_fifo_R1: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (!rx_polled && !tx_polled));

    assert_empty_no_head_err_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |-> (lsr[4:2] == 3'b000));

    assert_ovr_sets_R4: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> lsr[1]);

    assert_ovr_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (lsr[1] && !lsr_rd) |=> lsr[1]);

    assert_idle_implies_empty_R6: assert property (@(posedge clk) disable iff (rst)
        lsr[6] |-> lsr[5]);

    assert_tagged_push_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_push && (rx_push_tag != 3'b000) && !rx_pop && !rx_flush) |=> (!fifo_en || lsr[7]));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> !lsr[7]);

    assert_rx_quiet_polled_R9: assert property (@(posedge clk) disable iff (rst)
        rx_polled |-> !rx_notify);

    assert_tx_quiet_polled_R9: assert property (@(posedge clk) disable iff (rst)
        tx_polled |-> !tx_notify);
endmodule

bind uart_lsr_polled lsr_polled_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_lsr_polled_test.sv
module uart_lsr_polled_test;
    localparam int DEPTH = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fifo_en = 1'b0;
    logic [3:0]       ier = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             rx_push = 1'b0;
    logic [2:0]       rx_push_tag = '0;
    logic             rx_pop = 1'b0;
    logic [2:0]       rx_head_tag = '0;
    logic             rx_flush = 1'b0;
    logic             rx_overrun = 1'b0;
    logic             rx_trig_hit = 1'b0;
    logic             rx_timeout_hit = 1'b0;
    logic [CNT_W-1:0] tx_count = '0;
    logic             tsr_empty = 1'b1;
    logic             lsr_rd = 1'b0;
    logic [7:0]       lsr;
    logic             rx_polled, tx_polled, rx_notify, tx_notify;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [2:0] q_tags[$];
    bit         ovr_m = 0;

    uart_lsr_polled #(.DEPTH(DEPTH)) uut (.*);

    always #5 clk = ~clk;

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int tagged_in_q();
        int n = 0;
        foreach (q_tags[i]) if (q_tags[i] != 3'b000) n++;
        return n;
    endfunction

    function automatic logic [7:0] exp_lsr();
        logic [7:0] e;
        logic       has = (q_tags.size() != 0);
        e[0]   = has;
        e[1]   = ovr_m;
        e[4:2] = has ? q_tags[0] : 3'b000;
        e[5]   = (tx_count == '0);
        e[6]   = (tx_count == '0) && tsr_empty;
        e[7]   = fifo_en && (tagged_in_q() != 0);
        return e;
    endfunction

    task automatic check_all();
        logic [7:0] e = exp_lsr();
        cmp("R2", "ready", int'(lsr[0]), int'(e[0]));
        cmp("R4", "overrun", int'(lsr[1]), int'(e[1]));
        cmp("R3", "head errors", int'(lsr[4:2]), int'(e[4:2]));
        cmp("R5", "tx empty", int'(lsr[5]), int'(e[5]));
        cmp("R6", "tx idle", int'(lsr[6]), int'(e[6]));
        cmp("R7", "error summary", int'(lsr[7]), int'(e[7]));
        cmp("R1", "rx polled", int'(rx_polled), int'(fifo_en && !ier[0] && !ier[2]));
        cmp("R1", "tx polled", int'(tx_polled), int'(fifo_en && !ier[1]));
        cmp("R9", "rx notify", int'(rx_notify),
            int'(fifo_en && ier[0] && (rx_trig_hit || rx_timeout_hit)));
        cmp("R9", "tx notify", int'(tx_notify), int'(fifo_en && ier[1] && tx_count == '0));
    endtask

    task automatic drive_q();
        rx_count    = CNT_W'(q_tags.size());
        rx_head_tag = (q_tags.size() != 0) ? q_tags[0] : 3'b000;
    endtask

    task automatic advance();
        @(posedge clk);
        if (rx_flush) q_tags.delete();
        else begin
            if (rx_pop && q_tags.size() != 0) void'(q_tags.pop_front());
            if (rx_push) q_tags.push_back(rx_push_tag);
        end
        if (rx_overrun) ovr_m = 1;
        else if (lsr_rd) ovr_m = 0;
    endtask

    task automatic idle_inputs();
        rx_push = 0; rx_pop = 0; rx_flush = 0; rx_overrun = 0; lsr_rd = 0;
        rx_trig_hit = 0; rx_timeout_hit = 0; rx_push_tag = '0;
    endtask

    task automatic cycle();
        drive_q();
        #1 check_all();
        advance();
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // reset state: empty FIFOs, idle transmitter (R5, R6)
        #1 cmp("R5", "reset word", int'(lsr), 32'h60);
        @(negedge clk);

        // R4: overrun and read in the same cycle keeps the flag
        fifo_en = 1; ier = 4'b0000;
        rx_overrun = 1; lsr_rd = 1; cycle();
        idle_inputs(); #1 cmp("R4", "set wins over read", int'(lsr[1]), 1);
        lsr_rd = 1; cycle();
        idle_inputs(); #1 cmp("R4", "cleared by read", int'(lsr[1]), 0);
        @(negedge clk);

        // R7/R8: tagged pushes, then flush with a push in the same cycle
        rx_push = 1; rx_push_tag = 3'b010; cycle();
        rx_push = 1; rx_push_tag = 3'b000; cycle();
        idle_inputs();
        #1 cmp("R7", "tagged entry held", int'(lsr[7]), 1);
        fifo_en = 0; #1 cmp("R7", "fifo off masks summary", int'(lsr[7]), 0);
        fifo_en = 1;
        rx_flush = 1; rx_push = 1; rx_push_tag = 3'b100; cycle();
        idle_inputs(); drive_q();
        #1 cmp("R8", "flush clears summary", int'(lsr[7]), 0);
        cmp("R8", "flush drops push", int'(rx_count), 0);
        @(negedge clk);

        // R1: modem enable bit has no effect on polled flags
        ier = 4'b1000; #1 cmp("R1", "modem bit rx", int'(rx_polled), 1);
        cmp("R1", "modem bit tx", int'(tx_polled), 1);
        ier = 4'b0100; #1 cmp("R1", "line enable rx", int'(rx_polled), 0);
        cmp("R1", "line enable tx", int'(tx_polled), 1);
        @(negedge clk);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            fifo_en        = ($urandom_range(0, 9) != 0);
            ier            = 4'($urandom());
            rx_pop         = (q_tags.size() != 0) && $urandom_range(0, 1);
            rx_push        = (q_tags.size() < DEPTH) && $urandom_range(0, 1);
            rx_push_tag    = ($urandom_range(0, 9) < 3) ? 3'($urandom_range(1, 7)) : 3'b000;
            rx_flush       = ($urandom_range(0, 99) < 2);
            rx_overrun     = ($urandom_range(0, 9) == 0);
            lsr_rd         = ($urandom_range(0, 4) == 0);
            rx_trig_hit    = $urandom_range(0, 1);
            rx_timeout_hit = ($urandom_range(0, 3) == 0);
            tx_count       = ($urandom_range(0, 1)) ? '0 : CNT_W'($urandom_range(0, DEPTH));
            tsr_empty      = $urandom_range(0, 1);
            cycle();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule